// File: doc/BRIEF.md
# Two-dimensional memory-to-memory copy engine

This block copies a block of memory to another place with no help from software beyond programming two register sets. One register set describes the read side of the copy and the other describes the write side. Each set holds a byte start address, an element count per row, a signed byte step within the row, a row count, and a signed byte step that is applied when one row ends and the next begins. Each set also has a configuration word and a status word. Software writes both sets and then sets the enable bit on both configuration words. The read side then pulls elements through a simple memory read port with a latency of one cycle. The elements pass through a small FIFO, and the write side stores them through a memory write port in the same order.

An element is 8, 16 or 32 bits wide, and the data sits right-justified on both memory ports. If the steps are negative, both sides walk downward through memory. Software then points each start address at the last element, and an overlapping region can be moved safely to a higher address. The engine checks the pairing of the two register sets when a transfer starts. A mismatch or a misaligned address raises an error and no memory traffic takes place. A finished transfer sets a done flag in the write side's status word. That flag can drive an interrupt output.

Register address: bit 3 selects the set (0 read side, 1 write side). Bits 2:0 select the word: 0 start address, 1 row length, 2 row step, 3 row count, 4 row-end step, 5 configuration, 6 status.

Top module: `mdma2d`

## Requirements
- R1: After reset every register reads zero, rd_en, wr_en and irq are low, and no memory access takes place until both enable bits are set.
- R2: When configuration bit 0 (enable) is set on both sets, the read side has bit 1 clear and the write side has bit 1 set, the engine reads row-length elements. The first read is at the read start address, and each following read adds the row step. The engine writes the same elements, in the same order, starting at the write start address and adding the write row step each time. Counts are given in elements.
- R3: Configuration bits 3:2 select the element size: 00 is 8 bits, 01 is 16 bits and 10 is 32 bits. rd_size and wr_size carry this code. Element data sits in the low bits of rd_data and wr_data, and the bits above the element are zero on wr_data.
- R4: With configuration bit 4 set, the transfer moves row length × row count elements. After the last element of each row, the address advances by the row-end step instead of the row step.
- R5: Negative (two's complement) steps make both sides walk downward. A copy of an overlapping region to a higher address, started at the last element with a step of minus the element size, leaves the destination equal to the original source.
- R6: In the cycle after the final write, write-side status bit 0 (done) sets, status bit 2 (busy) clears, and the enable bits of both sets clear. Writing 1 to status bit 0 clears it. While a transfer runs, status bit 2 reads 1.
- R7: irq is high exactly while write-side status bit 0 is set and write-side configuration bit 5 (interrupt enable) is set.
- R8: If, at start, the element sizes differ, the size code is 11, the direction bits are wrong, the counts or bit 4 differ between the sets, or any start address or step used is not a multiple of the element size, then write-side status bit 1 (error) sets. Both enables clear, and no read or write takes place. Writing 1 to status bit 1 clears it.
- R9: Writing a configuration word with bit 0 clear to either set during a transfer stops all reads and writes from the next cycle on. Done does not set and busy clears.
- R10: Writing a configuration word with bit 6 (restart) set discards the FIFO contents and the running transfer. If both enables are still set, the transfer runs again from its first element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: set select and word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_size | output | 2 | Memory read element size code |
| rd_data | input | 32 | Read data, valid one cycle after rd_en |
| wr_en | output | 1 | Memory write request |
| wr_addr | output | 32 | Memory write byte address |
| wr_size | output | 2 | Memory write element size code |
| wr_data | output | 32 | Write data, right-justified |
| irq | output | 1 | Completion interrupt |

## Verification
Most faults in the address generators or the FIFO appear on the write port at the first bad element. A wrong step or row-end step gives a wrong wr_addr. A lost or duplicated FIFO entry gives wrong data. Either shows on the first write after the fault, so the bench compares every write against a precomputed stream. A fault in the sequencer shows as a write after a stop, a missing done flag, or a transfer that never ends, and each of these appears within a few cycles of the stop or of the last element. A faulty start check shows as memory traffic where an error was due, or as an error flag on a legal transfer.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
  parameter int AW = 32;
  parameter int CW = 16;

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  typedef struct packed {
    logic       irq_en;
    logic       twod;
    logic [1:0] wsize;
    logic       wr_dir;
    logic       en;
  } cfg_t;

  typedef struct packed {
    logic [AW-1:0] start;
    logic [CW-1:0] xcnt;
    logic [CW-1:0] xmod;
    logic [CW-1:0] ycnt;
    logic [CW-1:0] ymod;
    cfg_t          cfg;
    logic          done;
    logic          err;
  } chan_t;

  // a count of zero stands for the full 2^CW elements
  function automatic logic [CW:0] span(input logic [CW-1:0] c);
    return (c == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, c};
  endfunction

  function automatic logic [AW-1:0] stride(input logic [AW-1:0] a, input logic [CW-1:0] m);
    return a + {{(AW-CW){m[CW-1]}}, m};
  endfunction

  function automatic logic fits(input logic [1:0] low, input logic [1:0] ws);
    case (ws)
      2'd0:    return 1'b1;
      2'd1:    return ~low[0];
      2'd2:    return low == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] ws);
    case (ws)
      2'd0:    return 32'h0000_00ff;
      2'd1:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic cfg_bad(input chan_t s, input chan_t d);
    logic [1:0] ws;
    logic       bad;
    ws  = s.cfg.wsize;
    bad = (s.cfg.wsize != d.cfg.wsize) || (ws == 2'd3);
    bad = bad || s.cfg.wr_dir || !d.cfg.wr_dir;
    bad = bad || (s.xcnt != d.xcnt) || (s.cfg.twod != d.cfg.twod);
    bad = bad || (s.cfg.twod && (s.ycnt != d.ycnt));
    bad = bad || !fits(s.start[1:0], ws) || !fits(d.start[1:0], ws);
    bad = bad || !fits(s.xmod[1:0], ws) || !fits(d.xmod[1:0], ws);
    bad = bad || (s.cfg.twod && (!fits(s.ymod[1:0], ws) || !fits(d.ymod[1:0], ws)));
    return bad;
  endfunction
endpackage

// File: rtl/mdma_regs.sv
module mdma_regs
  import mdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [3:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy_i,
  input  logic              hw_done_i,
  input  logic              hw_err_i,
  input  logic              hw_clr_en_i,
  output chan_t [1:0]       ch_o,
  output logic              flush_o
);
  chan_t [1:0] ch_q;
  logic        sel;
  logic [2:0]  idx;

  assign sel  = addr[3];
  assign idx  = addr[2:0];
  assign ch_o = ch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_q    <= '0;
      flush_o <= 1'b0;
    end else begin
      flush_o <= we && (idx == 3'd5) && wdata[6];
      if (hw_clr_en_i) begin
        ch_q[0].cfg.en <= 1'b0;
        ch_q[1].cfg.en <= 1'b0;
      end
      if (we) begin
        case (idx)
          3'd0: ch_q[sel].start <= wdata[AW-1:0];
          3'd1: ch_q[sel].xcnt  <= wdata[CW-1:0];
          3'd2: ch_q[sel].xmod  <= wdata[CW-1:0];
          3'd3: ch_q[sel].ycnt  <= wdata[CW-1:0];
          3'd4: ch_q[sel].ymod  <= wdata[CW-1:0];
          3'd5: ch_q[sel].cfg   <= cfg_t'(wdata[5:0]);
          3'd6: begin
            if (wdata[0]) ch_q[sel].done <= 1'b0;
            if (wdata[1]) ch_q[sel].err  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (hw_done_i) ch_q[1].done <= 1'b1;
      if (hw_err_i)  ch_q[1].err  <= 1'b1;
    end
  end

  always_comb begin
    case (idx)
      3'd0:    rdata = 32'(ch_q[sel].start);
      3'd1:    rdata = 32'(ch_q[sel].xcnt);
      3'd2:    rdata = 32'(ch_q[sel].xmod);
      3'd3:    rdata = 32'(ch_q[sel].ycnt);
      3'd4:    rdata = 32'(ch_q[sel].ymod);
      3'd5:    rdata = 32'(ch_q[sel].cfg);
      3'd6:    rdata = {29'd0, busy_i, ch_q[sel].err, ch_q[sel].done};
      default: rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/mdma_agen.sv
module mdma_agen
  import mdma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic          step,
  input  logic [AW-1:0] start_i,
  input  logic [CW-1:0] xcnt_i,
  input  logic [CW-1:0] xmod_i,
  input  logic [CW-1:0] ycnt_i,
  input  logic [CW-1:0] ymod_i,
  input  logic          twod_i,
  output logic [AW-1:0] addr_o,
  output logic          active_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;
  logic [CW:0]   xleft, yleft, xspan;
  logic [CW-1:0] xmod_q, ymod_q;
  logic          active_q;
  logic          row_end, xfer_end;

  assign row_end  = (xleft == (CW+1)'(1));
  assign xfer_end = row_end && (yleft == (CW+1)'(1));
  assign addr_o   = addr_q;
  assign active_o = active_q;
  assign last_o   = active_q && xfer_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      xleft    <= '0;
      yleft    <= '0;
      xspan    <= '0;
      xmod_q   <= '0;
      ymod_q   <= '0;
      active_q <= 1'b0;
    end else if (clear) begin
      active_q <= 1'b0;
    end else if (load) begin
      addr_q   <= start_i;
      xleft    <= span(xcnt_i);
      xspan    <= span(xcnt_i);
      yleft    <= twod_i ? span(ycnt_i) : (CW+1)'(1);
      xmod_q   <= xmod_i;
      ymod_q   <= ymod_i;
      active_q <= 1'b1;
    end else if (step && active_q) begin
      if (xfer_end) begin
        active_q <= 1'b0;
      end else if (row_end) begin
        yleft  <= yleft - 1'b1;
        xleft  <= xspan;
        addr_q <= stride(addr_q, ymod_q);
      end else begin
        xleft  <= xleft - 1'b1;
        addr_q <= stride(addr_q, xmod_q);
      end
    end
  end

  // R2: a load points the generator at the programmed start
  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (addr_o == $past(start_i)) && active_o);

  // R4: the row-end step replaces the row step after the last element of a row
  a_r4_row_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && active_q && row_end && !xfer_end && !clear && !load)
      |=> addr_o == $past(addr_o) + AW'(signed'($past(ymod_q))));
endmodule

// File: rtl/mdma_fifo.sv
module mdma_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic [NW-1:0] count
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign dout  = store[rp];
  assign empty = (cnt_q == '0);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
    end else begin
      if (push) begin
        store[wp] <= din;
        wp        <= bump(wp);
      end
      if (pop) rp <= bump(rp);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2: the read credit keeps the buffer from overflowing or underflowing
  a_r2_fifo_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> (cnt_q < NW'(DEPTH)) || pop);
  a_r2_fifo_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> !empty);
endmodule

// File: rtl/mdma2d.sv
module mdma2d
  import mdma_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  localparam int NW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_size,
  input  logic [31:0]   rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [1:0]    wr_size,
  output logic [31:0]   wr_data,
  output logic          irq
);
  chan_t [1:0]   ch;
  state_t        state_q;
  logic          flush_q, both_en, kill, start_req, bad, start_ok, start_err, fin;
  logic          rd_pend, push, busy;
  logic [1:0]    ws_q;
  logic [31:0]   fifo_dout;
  logic          fifo_empty;
  logic [NW-1:0] fifo_cnt;
  logic [AW-1:0] agen_addr [2];
  logic          agen_act  [2];
  logic          agen_last [2];
  logic          agen_step [2];

  assign busy      = (state_q == ST_RUN);
  assign both_en   = ch[0].cfg.en && ch[1].cfg.en;
  assign kill      = flush_q || !both_en;
  assign start_req = (state_q == ST_IDLE) && both_en && !flush_q;
  assign bad       = cfg_bad(ch[0], ch[1]);
  assign start_ok  = start_req && !bad;
  assign start_err = start_req && bad;

  mdma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy_i(busy), .hw_done_i(fin), .hw_err_i(start_err),
    .hw_clr_en_i(fin || start_err), .ch_o(ch), .flush_o(flush_q)
  );

  for (genvar g = 0; g < 2; g++) begin : g_side
    mdma_agen u_agen (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .clear(kill), .step(agen_step[g]),
      .start_i(ch[g].start), .xcnt_i(ch[g].xcnt), .xmod_i(ch[g].xmod),
      .ycnt_i(ch[g].ycnt), .ymod_i(ch[g].ymod), .twod_i(ch[g].cfg.twod),
      .addr_o(agen_addr[g]), .active_o(agen_act[g]), .last_o(agen_last[g])
    );
  end

  // read credit: buffered plus outstanding elements stay below the depth
  assign rd_en = busy && !kill && agen_act[0] &&
                 ((32'(fifo_cnt) + 32'(rd_pend)) < 32'(FIFO_DEPTH));
  assign wr_en = busy && !kill && agen_act[1] && !fifo_empty;
  assign agen_step[0] = rd_en;
  assign agen_step[1] = wr_en;
  assign fin     = wr_en && agen_last[1];
  assign push    = rd_pend && busy && !kill;
  assign rd_addr = agen_addr[0];
  assign wr_addr = agen_addr[1];
  assign rd_size = ws_q;
  assign wr_size = ws_q;
  assign wr_data = fifo_dout;
  assign irq     = ch[1].done && ch[1].cfg.irq_en;

  mdma_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(kill), .push(push),
    .din(rd_data & lane_mask(ws_q)), .pop(wr_en),
    .dout(fifo_dout), .empty(fifo_empty), .count(fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_pend <= 1'b0;
      ws_q    <= 2'd0;
    end else begin
      rd_pend <= rd_en;
      if (start_ok) ws_q <= ch[0].cfg.wsize;
      case (state_q)
        ST_IDLE: if (start_ok) state_q <= ST_RUN;
        ST_RUN:  if (kill || fin) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: the final write sets done and ends the run
  a_r6_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> ch[1].done && !busy && !ch[1].cfg.en);
  // R8: a rejected start produces no memory traffic
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |=> !rd_en && !wr_en && ch[1].err);
  // R9: dropping an enable silences both ports
  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !both_en) |=> !rd_en && !wr_en);
  // R2: the read side never runs past its last element
  a_r2_src_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && agen_last[0]) |=> !agen_act[0]);
endmodule

// File: tb/sim_mdma2d.sv
`timescale 1ns/100ps
module sim_mdma2d;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        rd_en, wr_en, irq;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [31:0] rd_data = 32'd0;
  logic [1:0]  rd_size, wr_size;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  string wtag = "R2";
  logic [7:0]  bmem [1024];
  logic [31:0] exp_addr [$];
  logic [31:0] exp_data [$];
  logic [1:0]  exp_size [$];

  always #2.5 clk = ~clk;

  mdma2d u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data), .irq(irq)
  );

  function automatic logic [31:0] bmask(input logic [1:0] ws);
    return (ws == 2'd0) ? 32'hff : (ws == 2'd1) ? 32'hffff : 32'hffff_ffff;
  endfunction

  function automatic logic [31:0] peek(input logic [31:0] a, input logic [1:0] ws);
    logic [31:0] v;
    for (int b = 0; b < 4; b++) v[8*b +: 8] = bmem[(int'(a[9:0]) + b) % 1024];
    return v & bmask(ws);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: read data one cycle after the request, reads before writes
  always @(posedge clk) begin
    if (rd_en) rd_data <= peek(rd_addr, rd_size);
    if (wr_en)
      for (int b = 0; b < (1 << wr_size); b++)
        bmem[(int'(wr_addr[9:0]) + b) % 1024] = wr_data[8*b +: 8];
  end

  // every clock: a write must be the next one in the expected stream
  always @(negedge clk) begin
    if (rd_en) rd_cnt++;
    if (wr_en) begin
      if (exp_addr.size() == 0) chk({wtag, " write with none expected"}, 32'd1, 32'd0);
      else begin
        chk({wtag, " write address"}, wr_addr, exp_addr[0]);
        chk({wtag, " write data"}, wr_data, exp_data[0]);
        chk({wtag, " write size"}, 32'(wr_size), 32'(exp_size[0]));
        void'(exp_addr.pop_front());
        void'(exp_data.pop_front());
        void'(exp_size.pop_front());
      end
    end
  end

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cfgw(input bit en, input bit dir, input int ws,
                                       input bit twod, input bit ie, input bit fl);
    return {25'd0, fl, ie, twod, 2'(ws), dir, en};
  endfunction

  task automatic plan(input int sa, input int da, input int x, input int sxm, input int dxm,
                      input int y, input int sym, input int dym, input int ws);
    exp_addr.delete(); exp_data.delete(); exp_size.delete();
    for (int r = 0; r < y; r++)
      for (int c = 0; c < x; c++) begin
        int s, d;
        s = sa + r * ((x - 1) * sxm + sym) + c * sxm;
        d = da + r * ((x - 1) * dxm + dym) + c * dxm;
        exp_addr.push_back(32'(d));
        exp_data.push_back(peek(32'(s), 2'(ws)));
        exp_size.push_back(2'(ws));
      end
  endtask

  task automatic setup(input int sa, input int da, input int x, input int sxm, input int dxm,
                       input int y, input int sym, input int dym);
    reg_wr(4'd0, 32'(sa)); reg_wr(4'd1, 32'(x)); reg_wr(4'd2, 32'(sxm));
    reg_wr(4'd3, 32'(y));  reg_wr(4'd4, 32'(sym));
    reg_wr(4'd8, 32'(da)); reg_wr(4'd9, 32'(x)); reg_wr(4'd10, 32'(dxm));
    reg_wr(4'd11, 32'(y)); reg_wr(4'd12, 32'(dym));
  endtask

  task automatic go(input int sws, input int dws, input bit twod, input bit ie);
    reg_wr(4'd5, cfgw(1, 0, sws, twod, 0, 0));
    reg_wr(4'd13, cfgw(1, 1, dws, twod, ie, 0));
  endtask

  task automatic wait_end(output logic [31:0] st);
    st = 0;
    for (int i = 0; i < 5000; i++) begin
      reg_rd(4'd14, st);
      if (st[0] || st[1]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, st;
    int rd0;
    logic [31:0] orig [6];
    for (int i = 0; i < 1024; i++) bmem[i] = 8'(i * 7 + 3);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_en after reset", 32'(rd_en), 0);
    chk("R1 wr_en after reset", 32'(wr_en), 0);
    chk("R1 irq after reset", 32'(irq), 0);
    reg_rd(4'd14, v); chk("R1 status after reset", v, 0);
    reg_rd(4'd13, v); chk("R1 config after reset", v, 0);
    reg_rd(4'd8, v);  chk("R1 start after reset", v, 0);
    chk("R1 no reads after reset", 32'(rd_cnt), 0);

    // 1D 32-bit forward copy, interrupt enabled
    wtag = "R2";
    setup(32'h000, 32'h200, 8, 4, 4, 1, 0, 0);
    plan(32'h000, 32'h200, 8, 4, 4, 1, 0, 0, 2);
    go(2, 2, 0, 1);
    wait_end(st);
    chk("R6 done, not busy", st, 32'h1);
    chk("R2 stream complete", 32'(exp_addr.size()), 0);
    chk("R7 irq with done and enable", 32'(irq), 1);
    reg_rd(4'd13, v); chk("R6 write-side enable cleared", 32'(v[0]), 0);
    reg_rd(4'd5, v);  chk("R6 read-side enable cleared", 32'(v[0]), 0);
    reg_wr(4'd14, 32'h1);
    reg_rd(4'd14, v); chk("R6 done cleared by write one", v, 0);
    chk("R7 irq drops with done", 32'(irq), 0);

    // 1D 8-bit copy at odd addresses, interrupt disabled
    wtag = "R3";
    setup(32'h041, 32'h2A3, 5, 1, 1, 1, 0, 0);
    plan(32'h041, 32'h2A3, 5, 1, 1, 1, 0, 0, 0);
    go(0, 0, 0, 0);
    wait_end(st);
    chk("R3 8-bit done", st, 32'h1);
    chk("R3 8-bit stream complete", 32'(exp_addr.size()), 0);
    chk("R7 no irq when disabled", 32'(irq), 0);
    reg_wr(4'd14, 32'h1);

    // 2D 16-bit copy: gapped source rows into a packed destination
    wtag = "R4";
    setup(32'h080, 32'h300, 3, 2, 2, 4, 4, 2);
    plan(32'h080, 32'h300, 3, 2, 2, 4, 4, 2, 1);
    go(1, 1, 1, 0);
    wait_end(st);
    chk("R4 2D done", st, 32'h1);
    chk("R4 2D stream complete", 32'(exp_addr.size()), 0);
    reg_wr(4'd14, 32'h1);

    // backward copy of an overlapping region to a higher address
    wtag = "R5";
    for (int i = 0; i < 6; i++) orig[i] = peek(32'(32'h100 + 4 * i), 2'd2);
    setup(32'h114, 32'h11C, 6, -4, -4, 1, 0, 0);
    plan(32'h114, 32'h11C, 6, -4, -4, 1, 0, 0, 2);
    go(2, 2, 0, 0);
    wait_end(st);
    chk("R5 backward done", st, 32'h1);
    chk("R5 backward stream complete", 32'(exp_addr.size()), 0);
    for (int i = 0; i < 6; i++)
      chk("R5 moved word", peek(32'(32'h108 + 4 * i), 2'd2), orig[i]);
    reg_wr(4'd14, 32'h1);

    // mismatched element sizes
    wtag = "R8";
    exp_addr.delete(); exp_data.delete(); exp_size.delete();
    setup(32'h000, 32'h200, 4, 4, 2, 1, 0, 0);
    rd0 = rd_cnt;
    go(2, 1, 0, 0);
    wait_end(st);
    chk("R8 size mismatch sets error", st, 32'h2);
    chk("R8 no reads on error", 32'(rd_cnt - rd0), 0);
    reg_rd(4'd13, v); chk("R8 enable cleared on error", 32'(v[0]), 0);
    reg_wr(4'd14, 32'h2);
    reg_rd(4'd14, v); chk("R8 error cleared by write one", v, 0);

    // misaligned destination start for 32-bit elements
    setup(32'h000, 32'h202, 4, 4, 4, 1, 0, 0);
    rd0 = rd_cnt;
    go(2, 2, 0, 0);
    wait_end(st);
    chk("R8 misaligned start sets error", st, 32'h2);
    chk("R8 no reads on misaligned start", 32'(rd_cnt - rd0), 0);
    reg_wr(4'd14, 32'h2);

    // stop a long transfer by clearing the write-side enable
    wtag = "R9";
    setup(32'h000, 32'h200, 200, 1, 1, 1, 0, 0);
    plan(32'h000, 32'h200, 200, 1, 1, 1, 0, 0, 0);
    go(0, 0, 0, 0);
    repeat (20) @(posedge clk);
    reg_rd(4'd14, v); chk("R6 busy while running", v, 32'h4);
    reg_wr(4'd13, 32'h0);
    exp_addr.delete(); exp_data.delete(); exp_size.delete();
    rd0 = rd_cnt;
    repeat (12) @(posedge clk);
    chk("R9 no reads after stop", 32'(rd_cnt - rd0), 0);
    reg_rd(4'd14, v); chk("R9 no done, not busy after stop", v, 0);
    reg_wr(4'd5, 32'h0);

    // restart bit mid-transfer: the copy runs again from its first element
    wtag = "R10";
    setup(32'h000, 32'h300, 100, 1, 1, 1, 0, 0);
    plan(32'h000, 32'h300, 100, 1, 1, 1, 0, 0, 0);
    go(0, 0, 0, 0);
    repeat (12) @(posedge clk);
    reg_wr(4'd5, cfgw(1, 0, 0, 0, 0, 1));
    plan(32'h000, 32'h300, 100, 1, 1, 1, 0, 0, 0);
    wait_end(st);
    chk("R10 restarted copy completes", st, 32'h1);
    chk("R10 restarted stream complete", 32'(exp_addr.size()), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule